// File: doc/BRIEF.md
# Timed-Access Write Guard

This block decides when writes to protected register bits are allowed. Software unlocks them by writing a two-byte key to a dedicated key register. The two writes must come one after the other on the bus. A correct key opens a write-enable window. The window lasts a fixed number of machine-cycle ticks and then closes without any further action. There is no lasting unlock.

The block watches the bus write strobe, the write address and the write data, and it counts the machine-cycle tick. It drives one gate, `prot_en`. The logic that owns each protected bit ANDs its write strobe with this gate. The protected registers and the processor are not part of this block.

Top module: `ta_guard`

## Requirements
- R1: While reset is asserted, and in the first cycle after reset is released, `prot_en` is low.
- R2: The key is a write of 0xAA to address 0xC7, then a write of 0x55 to address 0xC7 as the very next bus write. `prot_en` goes high in the cycle after the edge that captures the second write.
- R3: Once open, the window counts the clock edges at which `mc_tick` is high. It closes on the edge of the third such tick. A tick that arrives in the same cycle as the opening write is not counted.
- R4: After 0xAA, the sequence aborts if the next write is anything other than 0x55 to 0xC7. That includes other data to 0xC7 and any write to another address. A later 0x55 on its own then does not open the window.
- R5: A write of 0xAA to 0xC7 after 0xAA counts as a fresh first key, so a 0x55 that follows it opens the window.
- R6: A write of 0x55 to 0xC7 with no 0xAA before it leaves `prot_en` low.
- R7: While the window is open, bus writes of any address and data, including key values, neither close the window early nor extend it.
- R8: Cycles with no bus write between the two key writes do not abort the sequence, and neither do ticks in those cycles.
- R9: When the window closes, the guard returns to idle, so a lone 0x55 does not reopen it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Bus write strobe |
| wr_addr | input | 8 | Write address in the special register space |
| wr_data | input | 8 | Write data |
| mc_tick | input | 1 | One-cycle pulse per machine cycle |
| prot_en | output | 1 | Gate for writes to protected bits |

## Verification
The checker covers the behaviour that must hold in every cycle:
- the gate only opens right after a 0x55 key write;
- it only closes on a tick;
- a cycle with the gate open and no tick keeps it open;
- the number of ticks seen in one open window never reaches the limit.

Some behaviour depends on history that a single property cannot see, and only the bench scenarios show it:
- whether a 0xAA came before the 0x55 (R6, R9);
- whether a stray write aborted the sequence (R4);
- whether a repeated 0xAA re-arms the guard (R5).

The cycle-level model compares against these scenarios on every clock.

// File: rtl/ta_guard.sv
module ta_guard #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 8'hC7,
  parameter logic [DATA_W-1:0] KEY_FIRST = 8'hAA,
  parameter logic [DATA_W-1:0] KEY_SECOND = 8'h55,
  parameter int WIN_TICKS = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              mc_tick,
  output logic              prot_en
);
  localparam int CNT_W = $clog2(WIN_TICKS + 1);

  typedef enum logic [1:0] {S_IDLE, S_ARMED, S_OPEN} st_t;

  st_t st_q, st_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  logic key_wr, first_wr, second_wr, last_tick;
  assign key_wr    = wr_en && (wr_addr == KEY_ADDR);
  assign first_wr  = key_wr && (wr_data == KEY_FIRST);
  assign second_wr = key_wr && (wr_data == KEY_SECOND);
  assign last_tick = mc_tick && (cnt_q == CNT_W'(WIN_TICKS - 1));

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    unique case (st_q)
      S_IDLE:
        if (first_wr) st_d = S_ARMED;
      S_ARMED:
        if (wr_en) begin
          if (second_wr) begin
            st_d  = S_OPEN;
            cnt_d = '0;
          end else if (first_wr) begin
            st_d = S_ARMED;
          end else begin
            st_d = S_IDLE;
          end
        end
      S_OPEN:
        if (last_tick) begin
          st_d  = S_IDLE;
          cnt_d = '0;
        end else if (mc_tick) begin
          cnt_d = cnt_q + 1'b1;
        end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= S_IDLE;
      cnt_q <= '0;
    end else begin
      st_q  <= st_d;
      cnt_q <= cnt_d;
    end
  end

  assign prot_en = (st_q == S_OPEN);
endmodule

module ta_guard_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8,
  parameter logic [ADDR_W-1:0] KEY_ADDR = 8'hC7,
  parameter logic [DATA_W-1:0] KEY_SECOND = 8'h55,
  parameter int WIN_TICKS = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [ADDR_W-1:0] wr_addr,
  input logic [DATA_W-1:0] wr_data,
  input logic              mc_tick,
  input logic              prot_en
);
  localparam int TW = $clog2(WIN_TICKS + 2);
  logic [TW-1:0] seen;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= '0;
    else if (!prot_en) seen <= '0;
    else if (mc_tick) seen <= seen + 1'b1;
  end

  // R2
  open_after_key_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(prot_en) |-> $past(wr_en && wr_addr == KEY_ADDR && wr_data == KEY_SECOND));

  // R3
  close_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(prot_en) |-> $past(mc_tick));

  // R7
  hold_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot_en && !mc_tick |=> prot_en);

  // R3
  window_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    prot_en |-> seen < TW'(WIN_TICKS));

  // R1
  always @(posedge clk)
    if (!rst_n) reset_low_chk: assert (!prot_en);
endmodule

bind ta_guard ta_guard_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .KEY_ADDR(KEY_ADDR),
  .KEY_SECOND(KEY_SECOND), .WIN_TICKS(WIN_TICKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
  .wr_data(wr_data), .mc_tick(mc_tick), .prot_en(prot_en)
);

// File: tb/sim_ta_guard.sv
`timescale 1ns/1ps
module sim_ta_guard;
  logic clk = 0, rst_n = 0, wr_en = 0, mc_tick = 0;
  logic [7:0] wr_addr = 0, wr_data = 0;
  logic prot_en;
  int total = 0, bad = 0;
  string tag = "R1";
  bit done = 0;

  always #2.5 clk = ~clk;

  ta_guard u0 (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
               .wr_data(wr_data), .mc_tick(mc_tick), .prot_en(prot_en));

  // reference: 0 idle, 1 armed, 2 open
  int m_stage = 0, m_ticks = 0;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin m_stage <= 0; m_ticks <= 0; end
    else if (m_stage == 2) begin
      if (mc_tick) begin
        if (m_ticks + 1 >= 3) begin m_stage <= 0; m_ticks <= 0; end
        else m_ticks <= m_ticks + 1;
      end
    end else if (wr_en) begin
      if (wr_addr == 8'hC7 && wr_data == 8'hAA) m_stage <= 1;
      else if (m_stage == 1 && wr_addr == 8'hC7 && wr_data == 8'h55) begin
        m_stage <= 2; m_ticks <= 0;
      end else m_stage <= 0;
    end
  end

  always @(negedge clk) begin
    total++;
    if (prot_en !== (m_stage == 2)) begin
      bad++;
      $display("FAIL %s model: prot_en=%b expected=%b", tag, prot_en, m_stage == 2);
    end
  end

  task automatic step(input bit w, input logic [7:0] a, input logic [7:0] d, input bit t);
    @(negedge clk);
    wr_en = w; wr_addr = a; wr_data = d; mc_tick = t;
    @(posedge clk); #1;
  endtask

  task automatic quiet(input int n);
    for (int i = 0; i < n; i++) step(0, 8'h00, 8'h00, 0);
  endtask

  task automatic chk(input string r, input bit exp);
    total++;
    if (prot_en !== exp) begin
      bad++;
      $display("FAIL %s: prot_en=%b expected=%b", r, prot_en, exp);
    end
  endtask

  task automatic unlock();
    step(1, 8'hC7, 8'hAA, 0);
    step(1, 8'hC7, 8'h55, 0);
  endtask

  task automatic close_window();
    for (int i = 0; i < 3; i++) step(0, 8'h00, 8'h00, 1);
    quiet(1);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 chk("R1", 0);
    @(negedge clk) rst_n = 1;
    @(posedge clk); #1 chk("R1", 0);

    tag = "R2"; unlock(); chk("R2", 1);
    tag = "R3"; step(0, 0, 0, 1); step(0, 0, 0, 1); chk("R3", 1);
    step(0, 0, 0, 0); chk("R3", 1);
    step(0, 0, 0, 1); chk("R3", 0);

    tag = "R3"; step(1, 8'hC7, 8'hAA, 0);
    step(1, 8'hC7, 8'h55, 1); chk("R3", 1);
    step(0, 0, 0, 1); step(0, 0, 0, 1); chk("R3", 1);
    step(0, 0, 0, 1); chk("R3", 0);

    tag = "R4"; step(1, 8'hC7, 8'hAA, 0); step(1, 8'hC7, 8'h12, 0);
    step(1, 8'hC7, 8'h55, 0); chk("R4", 0);
    step(1, 8'hC7, 8'hAA, 0); step(1, 8'h80, 8'h55, 0);
    step(1, 8'hC7, 8'h55, 0); chk("R4", 0);

    tag = "R5"; step(1, 8'hC7, 8'hAA, 0); step(1, 8'hC7, 8'hAA, 0);
    step(1, 8'hC7, 8'h55, 0); chk("R5", 1);
    close_window(); chk("R5", 0);

    tag = "R6"; step(1, 8'hC7, 8'h55, 0); chk("R6", 0);
    step(1, 8'hC7, 8'h55, 0); chk("R6", 0);

    tag = "R7"; unlock();
    step(1, 8'h90, 8'h01, 0); step(1, 8'hC7, 8'hAA, 0);
    step(1, 8'hC7, 8'h55, 1); chk("R7", 1);
    step(1, 8'hC7, 8'h00, 1); chk("R7", 1);
    step(1, 8'hC7, 8'hAA, 1); chk("R7", 0);

    tag = "R8"; step(1, 8'hC7, 8'hAA, 0); quiet(4); step(0, 0, 0, 1);
    step(1, 8'hC7, 8'h55, 0); chk("R8", 1);
    close_window();

    tag = "R9"; quiet(1); chk("R9", 0);
    step(1, 8'hC7, 8'h55, 0); chk("R9", 0);
    quiet(2); chk("R9", 0);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog: run hung, expected completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule